// File: doc/BRIEF.md
# DMA Descriptor Condition Decision Unit

This block makes the three control decisions a descriptor-driven DMA channel needs once a descriptor's work is done: whether to raise an interrupt, whether to hold and wait, and whether to jump to a new descriptor or step to the next one. It is strobed once per descriptor completion. It returns its decisions one clock later, together with the next command pointer and the branch-taken status bit.

Every decision uses the same masked-compare test. Each decision has its own select register. That register holds a mask and a compare value, and the masked compare is applied to the channel's device-status nibble. Each decision also has its own 2-bit mode field in the command word. The mode says whether the result of the compare is ignored, required to be true, or required to be false.

Top module: `dma_cond_unit`

## Requirements
- R1: In each 32-bit select word, the 4-bit mask sits in bits 19:16 and the 4-bit compare value in bits 3:0. All other bits have no effect on any output.
- R2: A decision's condition is true when (dev_stat_i & mask) == (value & mask). A zero mask therefore always gives a true condition.
- R3: `cmd_modes_i` carries the interrupt mode in bits 5:4, the branch mode in bits 3:2 and the wait mode in bits 1:0. Mode 00 never acts and mode 11 always acts, regardless of the condition.
- R4: Mode 01 acts only when the decision's condition is true. Mode 10 acts only when it is false.
- R5: The interrupt decision uses `intr_sel_i`, the branch decision uses `branch_sel_i` and the wait decision uses `wait_sel_i`. None of them is affected by the other two select words.
- R6: On a step that does not wait and takes the branch, `next_ptr_o` becomes `branch_tgt_i` and `bt_o` becomes 1.
- R7: On a step that does not wait and does not take the branch, `next_ptr_o` becomes `cmd_ptr_i + 16` and `bt_o` becomes 0.
- R8: On a step whose wait decision acts, `wait_o` is 1, `intr_o` stays 0, and `next_ptr_o` and `bt_o` keep their previous values.
- R9: The results of a strobe appear in the cycle after it, marked by a one-cycle `valid_o`. `intr_o` is high for at most that one cycle. Without a strobe, `intr_o` is 0 and `next_ptr_o`, `bt_o` and `wait_o` hold.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Evaluate the current descriptor |
| cmd_modes_i | input | 6 | Interrupt, branch and wait mode fields |
| dev_stat_i | input | 4 | Device-status bits of the channel status |
| intr_sel_i | input | 32 | Interrupt select word (mask and value) |
| branch_sel_i | input | 32 | Branch select word (mask and value) |
| wait_sel_i | input | 32 | Wait select word (mask and value) |
| cmd_ptr_i | input | 32 | Current command pointer |
| branch_tgt_i | input | 32 | Branch target from the descriptor |
| valid_o | output | 1 | Decisions valid, one cycle after strobe |
| intr_o | output | 1 | Interrupt pulse |
| wait_o | output | 1 | Channel must wait on this descriptor |
| next_ptr_o | output | 32 | Next command pointer |
| bt_o | output | 1 | Branch-taken status bit |

## Verification
The properties assume that the operands seen at a strobe are the ones the registered outputs reflect one cycle later. They also assume that strobes come from a synchronous source that is low during reset. The stimulus changes every input only at the falling clock edge. It holds `strobe_i` low through reset. Its random steps mix back-to-back strobes with idle gaps, draw select words with random filler bits outside the mask and value fields, and cover every mode code.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  typedef enum logic [1:0] {
    MODE_NEVER  = 2'b00,
    MODE_IF_SET = 2'b01,
    MODE_IF_CLR = 2'b10,
    MODE_ALWAYS = 2'b11
  } act_mode_e;

  localparam int NUM_DEC   = 3;
  localparam int DEC_WAIT  = 0;  // cmd_modes bits 1:0
  localparam int DEC_BR    = 1;  // cmd_modes bits 3:2
  localparam int DEC_INTR  = 2;  // cmd_modes bits 5:4
  localparam int MODE_W    = 2;
  localparam int MASK_LSB  = 16;
  localparam int VAL_LSB   = 0;
endpackage

// File: rtl/dcu_cond_eval.sv
module dcu_cond_eval #(
  parameter int STAT_W = 4
) (
  input  logic [STAT_W-1:0] mask_i,
  input  logic [STAT_W-1:0] val_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              match_o
);
  assign match_o = ((stat_i & mask_i) == (val_i & mask_i));
endmodule

// File: rtl/dcu_mode_gate.sv
module dcu_mode_gate
  import dcu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              match_i,
  output logic              act_o
);
  always_comb begin
    unique case (act_mode_e'(mode_i))
      MODE_NEVER:  act_o = 1'b0;
      MODE_IF_SET: act_o = match_i;
      MODE_IF_CLR: act_o = ~match_i;
      default:     act_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dcu_ptr_next.sv
module dcu_ptr_next #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 16
) (
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] cmd_ptr_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              bt_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  assign ptr_o = taken_i ? tgt_i : cmd_ptr_i + STEP_V;
  assign bt_o  = taken_i;
endmodule

// File: rtl/dma_cond_unit.sv
module dma_cond_unit
  import dcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 4,
  parameter int SEL_W  = 32,
  parameter int STEP   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      strobe_i,
  input  logic [NUM_DEC*MODE_W-1:0] cmd_modes_i,
  input  logic [STAT_W-1:0]         dev_stat_i,
  input  logic [SEL_W-1:0]          intr_sel_i,
  input  logic [SEL_W-1:0]          branch_sel_i,
  input  logic [SEL_W-1:0]          wait_sel_i,
  input  logic [ADDR_W-1:0]         cmd_ptr_i,
  input  logic [ADDR_W-1:0]         branch_tgt_i,
  output logic                      valid_o,
  output logic                      intr_o,
  output logic                      wait_o,
  output logic [ADDR_W-1:0]         next_ptr_o,
  output logic                      bt_o
);
  logic [SEL_W-1:0]  sel_arr [NUM_DEC];
  logic [NUM_DEC-1:0] act;

  assign sel_arr[DEC_WAIT] = wait_sel_i;
  assign sel_arr[DEC_BR]   = branch_sel_i;
  assign sel_arr[DEC_INTR] = intr_sel_i;

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    logic match;
    dcu_cond_eval #(.STAT_W(STAT_W)) u_cond (
      .mask_i  (sel_arr[d][MASK_LSB +: STAT_W]),
      .val_i   (sel_arr[d][VAL_LSB +: STAT_W]),
      .stat_i  (dev_stat_i),
      .match_o (match)
    );
    dcu_mode_gate u_gate (
      .mode_i  (cmd_modes_i[d*MODE_W +: MODE_W]),
      .match_i (match),
      .act_o   (act[d])
    );
  end

  // filler bits of the select words carry no function
  logic unused_sel_bits;
  always_comb begin
    unused_sel_bits = 1'b0;
    for (int d = 0; d < NUM_DEC; d++) begin
      for (int b = 0; b < SEL_W; b++) begin
        if (!((b >= MASK_LSB && b < MASK_LSB + STAT_W) ||
              (b >= VAL_LSB && b < VAL_LSB + STAT_W)))
          unused_sel_bits = unused_sel_bits ^ sel_arr[d][b];
      end
    end
  end

  logic [ADDR_W-1:0] ptr_nxt;
  logic              bt_nxt;

  dcu_ptr_next #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
    .taken_i   (act[DEC_BR]),
    .cmd_ptr_i (cmd_ptr_i),
    .tgt_i     (branch_tgt_i),
    .ptr_o     (ptr_nxt),
    .bt_o      (bt_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      intr_o     <= 1'b0;
      wait_o     <= 1'b0;
      next_ptr_o <= '0;
      bt_o       <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      intr_o  <= strobe_i & ~act[DEC_WAIT] & act[DEC_INTR];
      if (strobe_i) begin
        wait_o <= act[DEC_WAIT];
        // waiting leaves pointer and branch flag untouched
        if (!act[DEC_WAIT]) begin
          next_ptr_o <= ptr_nxt;
          bt_o       <= bt_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/dcu_checker.sv
module dcu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic [5:0]        cmd_modes_i,
  input logic [ADDR_W-1:0] cmd_ptr_i,
  input logic [ADDR_W-1:0] branch_tgt_i,
  input logic              valid_o,
  input logic              intr_o,
  input logic              wait_o,
  input logic [ADDR_W-1:0] next_ptr_o,
  input logic              bt_o
);
  a_r9_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strobe_i));

  a_r9_intr_only_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> valid_o);

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !intr_o && $stable(next_ptr_o) && $stable(bt_o) && $stable(wait_o));

  a_r8_wait_blocks_intr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wait_o) |-> !intr_o);

  a_r8_wait_holds_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && cmd_modes_i[1:0] == 2'b11) |=> wait_o && $stable(next_ptr_o) && $stable(bt_o));

  a_r6_taken_loads_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wait_o && bt_o) |-> next_ptr_o == $past(branch_tgt_i));

  a_r7_step_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wait_o && !bt_o) |-> next_ptr_o == $past(cmd_ptr_i) + ADDR_W'(16));

  a_r3_always_intr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && cmd_modes_i[5:4] == 2'b11 && cmd_modes_i[1:0] == 2'b00) |=> intr_o);

  a_r3_never_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && cmd_modes_i[3:2] == 2'b00 && cmd_modes_i[1:0] == 2'b00) |=> !bt_o);
endmodule

bind dma_cond_unit dcu_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_cond_unit.sv
module sim_dma_cond_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [5:0]  cmd_modes_i = '0;
  logic [3:0]  dev_stat_i = '0;
  logic [31:0] intr_sel_i = '0, branch_sel_i = '0, wait_sel_i = '0;
  logic [31:0] cmd_ptr_i = '0, branch_tgt_i = '0;
  logic        valid_o, intr_o, wait_o, bt_o;
  logic [31:0] next_ptr_o;

  int tests = 0, fails = 0;
  logic [31:0] exp_ptr = '0;
  logic        exp_bt = 1'b0, exp_wait = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_cond_unit u0 (.*);

  function automatic bit cond_f(logic [31:0] sel, logic [3:0] st);
    return (st & sel[19:16]) == (sel[3:0] & sel[19:16]);
  endfunction

  function automatic bit act_f(logic [1:0] m, bit c);
    case (m)
      2'b00: return 1'b0;
      2'b01: return c;
      2'b10: return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step(logic [5:0] m, logic [3:0] st, logic [31:0] is, logic [31:0] bs,
                      logic [31:0] ws, logic [31:0] cp, logic [31:0] tg, string req);
    bit w, i, b;
    cmd_modes_i = m; dev_stat_i = st; intr_sel_i = is; branch_sel_i = bs;
    wait_sel_i = ws; cmd_ptr_i = cp; branch_tgt_i = tg; strobe_i = 1'b1;
    w = act_f(m[1:0], cond_f(ws, st));
    i = act_f(m[5:4], cond_f(is, st)) && !w;
    b = act_f(m[3:2], cond_f(bs, st));
    exp_wait = w;
    if (!w) begin
      exp_ptr = b ? tg : cp + 32'd16;
      exp_bt  = b;
    end
    @(negedge clk_i);
    strobe_i = 1'b0;
    chk({req, " R9 valid"}, 32'(valid_o), 32'd1);
    chk({req, " intr"}, 32'(intr_o), 32'(i));
    chk({req, " wait"}, 32'(wait_o), 32'(exp_wait));
    chk({req, " ptr"}, next_ptr_o, exp_ptr);
    chk({req, " bt"}, 32'(bt_o), 32'(exp_bt));
  endtask

  task automatic idle(string req);
    @(negedge clk_i);
    chk({req, " idle valid"}, 32'(valid_o), 32'd0);
    chk({req, " idle intr"}, 32'(intr_o), 32'd0);
    chk({req, " idle ptr"}, next_ptr_o, exp_ptr);
    chk({req, " idle bt"}, 32'(bt_o), 32'(exp_bt));
    chk({req, " idle wait"}, 32'(wait_o), 32'(exp_wait));
  endtask

  initial begin
    #20000000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R10 valid", 32'(valid_o), 0); chk("R10 intr", 32'(intr_o), 0);
    chk("R10 wait", 32'(wait_o), 0);   chk("R10 ptr", next_ptr_o, 0);
    chk("R10 bt", 32'(bt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 always interrupt, never branch, never wait
    step(6'b11_00_00, 4'h0, 0, 0, 0, 32'h1000, 32'h2000, "R3 always/never");
    idle("R9");
    // R3 always branch
    step(6'b00_11_00, 4'h0, 0, 0, 0, 32'h1010, 32'h3000, "R6 always branch");
    // R7 step clears bt
    step(6'b00_00_00, 4'h0, 0, 0, 0, 32'h3000, 32'h4000, "R7 advance");
    // R2 zero mask => true; R4 if-clr must not act
    step(6'b10_10_00, 4'h5, 0, 32'h0000_000F, 0, 32'h4000, 32'h5000, "R2 zero mask");
    // R4 if-set with match and mismatch
    step(6'b01_01_00, 4'hA, 32'h000F_000A, 32'h000F_000B, 0, 32'h5000, 32'h6000, "R4 set");
    step(6'b10_10_00, 4'hA, 32'h000F_000A, 32'h000F_000B, 0, 32'h5010, 32'h6000, "R4 clr");
    // R1 filler bits ignored: match only in masked fields
    step(6'b01_01_00, 4'h3, 32'hFFF3_FFF3, 32'hA5C3_5A53, 0, 32'h7000, 32'h8000, "R1 filler");
    // R5 separate select words
    step(6'b01_01_00, 4'h1, 32'h0001_0001, 32'h0001_0000, 32'h0001_0000, 32'h9000, 32'hA000, "R5 split");
    // R8 wait blocks intr and pointer update
    step(6'b11_11_11, 4'h0, 0, 0, 0, 32'hB000, 32'hC000, "R8 wait always");
    idle("R8");
    step(6'b11_11_01, 4'h2, 0, 0, 32'h0002_0002, 32'hB000, 32'hC000, "R8 wait ifset");
    step(6'b11_00_10, 4'h2, 0, 0, 32'h0002_0002, 32'hB000, 32'hC000, "R8 wait released");
    for (int n = 0; n < 400; n++) begin
      step(6'($urandom), 4'($urandom),
           {12'($urandom), 4'($urandom), 12'($urandom), 4'($urandom)},
           {12'($urandom), 4'($urandom), 12'($urandom), 4'($urandom)},
           {12'($urandom), 4'($urandom), 12'($urandom), 4'($urandom)},
           $urandom & 32'hFFFF_FFF0, $urandom & 32'hFFFF_FFF0, "R4 random");
      if ($urandom_range(3) == 0) idle("R9 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule